// File: doc/BRIEF.md
# Structured VDM Identity Responder

This block sits behind a power-delivery protocol receiver on the cable-plug side of a link. It takes one decoded 32-bit vendor-defined message header per request, strobed by a valid pulse, and decides whether the header asks for the cable's identity. A well-formed request must be structured, carry the standard PD SID, be an initiator request and use command code 1. For such a request the block streams a five-word reply on a ready/valid interface. The words are the acknowledging header, the identity header, the certification-status object, the product object and the cable object.

All identity values come from static configuration inputs and are packed into the words as they stream out. The block only ever responds. A request that does not qualify produces nothing. A request that arrives while a reply is still streaming cuts that reply short, raises a one-cycle abort flag and is then handled like any other request.

Top module: `vdm_id_responder`

## Requirements
- R1: After synchronous active-high reset `out_valid` and `abort` are low. `out_valid` stays low until a qualifying request has been accepted.
- R2: A request qualifies when all four of these hold: bit 15 is 1, bits 31:16 equal the SID parameter (default 16'hFF00), bits 7:6 are 00 and bits 4:0 equal 1. Bits 14:8 and bit 5 of the request do not affect qualification.
- R3: With no reply in progress, a non-qualifying request (unstructured, other SID, other command code or a non-initiator type) leaves `out_valid` and `abort` low.
- R4: Word 0 of a reply has the SID in bits 31:16, 1 in bit 15, 0 in bits 14:8, 01 in bits 7:6, 0 in bit 5 and 1 in bits 4:0. With the default SID this is 32'hFF008041.
- R5: Word 1 is the identity header. It has host-capable at bit 31, device-capable at bit 30, product type at bits 29:27, modal support at bit 26, zeros at bits 25:16 and the vendor ID at bits 15:0.
- R6: Word 2 has zeros in bits 31:20 and the 20-bit test ID in bits 19:0.
- R7: Word 3 has the product ID in bits 31:16 and the device release number in bits 15:0.
- R8: Word 4 is the cable object. It has the hardware version in 31:28, the firmware version in 27:24, zeros in 23:20, the far-end connector code in 19:18, the receptacle flag in bit 17 and zeros in 16:0.
- R9: Words leave in the order 0,1,2,3,4. `out_last` is high only on word 4, and `out_count` reads 5 whenever `out_valid` is high.
- R10: A word is held stable while `out_valid` is high and `out_ready` is low. Each accepted word moves to the next one. After word 4 is accepted, `out_valid` is low in the next cycle.
- R11: Any request that arrives while `out_valid` is high raises `abort` for exactly the next cycle. If that request qualifies, the reply restarts at word 0 in that cycle; otherwise `out_valid` is low.
- R12: A reply begins with word 0 in the cycle after a qualifying request, and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request header strobe |
| req_hdr | input | 32 | Received VDM header |
| cfg_host_cap | input | 1 | Host-capable flag |
| cfg_dev_cap | input | 1 | Device-capable flag |
| cfg_prod_type | input | 3 | Product type code |
| cfg_modal | input | 1 | Modal operation supported |
| cfg_vendor_id | input | 16 | Vendor ID |
| cfg_test_id | input | 20 | Certification test ID |
| cfg_product_id | input | 16 | Product ID |
| cfg_release | input | 16 | Device release number |
| cfg_hw_ver | input | 4 | Cable hardware version |
| cfg_fw_ver | input | 4 | Cable firmware version |
| cfg_far_conn | input | 2 | Far-end connector code |
| cfg_receptacle | input | 1 | Receptacle flag |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Reply word valid |
| out_data | output | 32 | Reply word |
| out_last | output | 1 | Final word of reply |
| out_count | output | 3 | Number of data objects in the reply |
| abort | output | 1 | One-cycle flag: reply cut short by a new request |

## Verification
The qualification logic is tried with one header that matches and with variants that each break exactly one condition: type bit, SID, command code or command type. This shows that each condition is checked on its own. A matching header with the ignored bits set separates a decoder that masks reserved bits from one that compares the whole word. Replies are drained with ready held high and with ready toggling, which separates correct stalling from premature advance. Two product configurations expose mis-packed fields. New requests are injected mid-stream and on the final word, and are either qualifying or not, to show that abort and restart are separate behaviours.

// File: rtl/vdm_id_pkg.sv
package vdm_id_pkg;

  localparam int unsigned NUM_OBJ = 5;
  localparam int unsigned IDX_W   = $clog2(NUM_OBJ);
  localparam int unsigned CNT_W   = $clog2(NUM_OBJ + 1);
  localparam int unsigned CMD_DISCOVER_ID = 1;
  localparam logic [1:0]  TYPE_INITIATOR = 2'b00;
  localparam logic [1:0]  TYPE_ACK       = 2'b01;

  typedef struct packed {
    logic        host_cap;
    logic        dev_cap;
    logic [2:0]  prod_type;
    logic        modal;
    logic [15:0] vendor_id;
    logic [19:0] test_id;
    logic [15:0] product_id;
    logic [15:0] release_num;
    logic [3:0]  hw_ver;
    logic [3:0]  fw_ver;
    logic [1:0]  far_conn;
    logic        receptacle;
  } id_cfg_t;

  function automatic logic is_identity_req(input logic [31:0] h, input logic [15:0] sid);
    return h[15] && (h[31:16] == sid) && (h[7:6] == TYPE_INITIATOR) &&
           (h[4:0] == 5'(CMD_DISCOVER_ID));
  endfunction

  function automatic logic [31:0] ack_header(input logic [15:0] sid);
    return {sid, 1'b1, 2'b00, 2'b00, 3'b000, TYPE_ACK, 1'b0, 5'(CMD_DISCOVER_ID)};
  endfunction

  function automatic logic [31:0] id_header(input id_cfg_t c);
    return {c.host_cap, c.dev_cap, c.prod_type, c.modal, 10'd0, c.vendor_id};
  endfunction

  function automatic logic [31:0] cert_obj(input id_cfg_t c);
    return {12'd0, c.test_id};
  endfunction

  function automatic logic [31:0] product_obj(input id_cfg_t c);
    return {c.product_id, c.release_num};
  endfunction

  function automatic logic [31:0] cable_obj(input id_cfg_t c);
    return {c.hw_ver, c.fw_ver, 4'd0, c.far_conn, c.receptacle, 17'd0};
  endfunction

endpackage

// File: rtl/vdm_req_qualify.sv
module vdm_req_qualify
  import vdm_id_pkg::*;
#(
  parameter logic [15:0] SID = 16'hFF00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_hdr,
  output logic        req_hit
);

  logic structured;
  assign structured = req_hdr[15];
  assign req_hit = req_valid && is_identity_req(req_hdr, SID);

  // R2
  unstructured_never_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !structured) |-> !req_hit);

endmodule

// File: rtl/vdm_obj_mux.sv
module vdm_obj_mux
  import vdm_id_pkg::*;
#(
  parameter logic [15:0] SID = 16'hFF00
) (
  input  logic [IDX_W-1:0] idx,
  input  id_cfg_t          cfg,
  output logic [31:0]      word
);

  always_comb begin
    case (idx)
      IDX_W'(0): word = ack_header(SID);
      IDX_W'(1): word = id_header(cfg);
      IDX_W'(2): word = cert_obj(cfg);
      IDX_W'(3): word = product_obj(cfg);
      default:   word = cable_obj(cfg);
    endcase
  end

endmodule

// File: rtl/vdm_reply_seq.sv
module vdm_reply_seq
  import vdm_id_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_hit,
  input  logic             out_ready,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             last_word,
  output logic             abort
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OBJ - 1);

  logic active_q;
  logic [IDX_W-1:0] idx_q;
  logic abort_q;
  logic accept;

  assign accept    = active_q && out_ready;
  assign active    = active_q;
  assign idx       = idx_q;
  assign last_word = active_q && (idx_q == LAST_IDX);
  assign abort     = abort_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (req_valid) begin
        abort_q  <= active_q;
        active_q <= req_hit;
        idx_q    <= '0;
      end else if (accept) begin
        if (idx_q == LAST_IDX) begin
          active_q <= 1'b0;
          idx_q    <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R12
  start_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> $past(req_hit));
  // R10
  stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && !out_ready && !req_valid) |=> (active_q && $stable(idx_q)));
  // R10
  end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (last_word && out_ready && !req_valid) |=> !active_q);
  // R11
  abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |-> ($past(req_valid) && $past(active_q)));
  // R11
  abort_single_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> !abort_q || $past(req_valid));

endmodule

// File: rtl/vdm_id_responder.sv
module vdm_id_responder
  import vdm_id_pkg::*;
#(
  parameter logic [15:0] SID = 16'hFF00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_hdr,
  input  logic        cfg_host_cap,
  input  logic        cfg_dev_cap,
  input  logic [2:0]  cfg_prod_type,
  input  logic        cfg_modal,
  input  logic [15:0] cfg_vendor_id,
  input  logic [19:0] cfg_test_id,
  input  logic [15:0] cfg_product_id,
  input  logic [15:0] cfg_release,
  input  logic [3:0]  cfg_hw_ver,
  input  logic [3:0]  cfg_fw_ver,
  input  logic [1:0]  cfg_far_conn,
  input  logic        cfg_receptacle,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        out_last,
  output logic [2:0]  out_count,
  output logic        abort
);

  id_cfg_t          cfg;
  logic             req_hit;
  logic             seq_active;
  logic [IDX_W-1:0] seq_idx;
  logic             seq_last;
  logic             first_word;

  assign cfg = '{host_cap: cfg_host_cap, dev_cap: cfg_dev_cap, prod_type: cfg_prod_type,
                 modal: cfg_modal, vendor_id: cfg_vendor_id, test_id: cfg_test_id,
                 product_id: cfg_product_id, release_num: cfg_release,
                 hw_ver: cfg_hw_ver, fw_ver: cfg_fw_ver, far_conn: cfg_far_conn,
                 receptacle: cfg_receptacle};

  vdm_req_qualify #(.SID(SID)) u_qual (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_hdr(req_hdr), .req_hit(req_hit)
  );

  vdm_reply_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_hit(req_hit), .out_ready(out_ready),
    .active(seq_active), .idx(seq_idx), .last_word(seq_last), .abort(abort)
  );

  vdm_obj_mux #(.SID(SID)) u_mux (
    .idx(seq_idx), .cfg(cfg), .word(out_data)
  );

  assign out_valid  = seq_active;
  assign out_last   = seq_last;
  assign out_count  = seq_active ? 3'(NUM_OBJ) : 3'd0;
  assign first_word = seq_active && (seq_idx == '0);

  // R9
  last_first_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({first_word, out_last}));
  // R9
  last_implies_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R10
  data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !req_valid) |=> $stable(out_data));
  // R3
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && req_valid && !req_hit) |=> (!out_valid && !abort));

endmodule

// File: tb/vdm_id_responder_bench.sv
module vdm_id_responder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_hdr = '0;
  logic cfg_host_cap = 0, cfg_dev_cap = 0, cfg_modal = 0, cfg_receptacle = 0;
  logic [2:0] cfg_prod_type = 0;
  logic [15:0] cfg_vendor_id = 0, cfg_product_id = 0, cfg_release = 0;
  logic [19:0] cfg_test_id = 0;
  logic [3:0] cfg_hw_ver = 0, cfg_fw_ver = 0;
  logic [1:0] cfg_far_conn = 0;
  logic out_ready = 1'b0;
  logic out_valid, out_last, abort;
  logic [31:0] out_data;
  logic [2:0] out_count;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  logic exp_abort = 1'b0;

  always #5 clk = ~clk;

  vdm_id_responder u_vdm_id_responder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_hdr(req_hdr),
    .cfg_host_cap(cfg_host_cap), .cfg_dev_cap(cfg_dev_cap), .cfg_prod_type(cfg_prod_type),
    .cfg_modal(cfg_modal), .cfg_vendor_id(cfg_vendor_id), .cfg_test_id(cfg_test_id),
    .cfg_product_id(cfg_product_id), .cfg_release(cfg_release), .cfg_hw_ver(cfg_hw_ver),
    .cfg_fw_ver(cfg_fw_ver), .cfg_far_conn(cfg_far_conn), .cfg_receptacle(cfg_receptacle),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_count(out_count), .abort(abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic qualifies(input logic [31:0] h);
    return (h >> 15) % 2 == 1 && (h >> 16) == 32'h0000FF00 &&
           ((h >> 6) % 4) == 0 && (h % 32) == 1;
  endfunction

  task automatic load_reply();
    logic [31:0] w;
    exp_q.delete();
    exp_q.push_back(32'hFF008041);
    w = 32'(cfg_host_cap) * 32'h8000_0000 + 32'(cfg_dev_cap) * 32'h4000_0000 +
        32'(cfg_prod_type) * 32'h0800_0000 + 32'(cfg_modal) * 32'h0400_0000 + 32'(cfg_vendor_id);
    exp_q.push_back(w);
    exp_q.push_back(32'(cfg_test_id));
    exp_q.push_back(32'(cfg_product_id) * 32'h1_0000 + 32'(cfg_release));
    w = 32'(cfg_hw_ver) * 32'h1000_0000 + 32'(cfg_fw_ver) * 32'h0100_0000 +
        32'(cfg_far_conn) * 32'h4_0000 + 32'(cfg_receptacle) * 32'h2_0000;
    exp_q.push_back(w);
  endtask

  function automatic string word_req(input int left);
    case (left)
      5: return "R4";
      4: return "R5";
      3: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic compare(input string tag);
    chk({tag, " R1/R12 valid"}, 32'(out_valid), 32'(exp_q.size() > 0));
    chk({tag, " R11 abort"}, 32'(abort), 32'(exp_abort));
    if (exp_q.size() > 0 && out_valid) begin
      chk({tag, " ", word_req(exp_q.size()), " word"}, out_data, exp_q[0]);
      chk({tag, " R9 last"}, 32'(out_last), 32'(exp_q.size() == 1));
      chk({tag, " R9 count"}, 32'(out_count), 32'd5);
    end
  endtask

  task automatic step(input logic rv, input logic [31:0] h, input logic rdy, input string tag);
    @(negedge clk);
    req_valid = rv; req_hdr = h; out_ready = rdy;
    #1;
    compare(tag);
    @(posedge clk);
    exp_abort = 1'b0;
    if (rv) begin
      exp_abort = (exp_q.size() > 0);
      if (qualifies(h)) load_reply();
      else exp_q.delete();
    end else if (rdy && exp_q.size() > 0) begin
      void'(exp_q.pop_front());
    end
  endtask

  task automatic idle(input int n, input logic rdy, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, rdy, tag);
  endtask

  localparam logic [31:0] GOOD = 32'hFF008001;

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_host_cap = 0; cfg_dev_cap = 1; cfg_prod_type = 3'b011; cfg_modal = 0;
    cfg_vendor_id = 16'h1A2B; cfg_test_id = 20'hABCDE; cfg_product_id = 16'h5566;
    cfg_release = 16'h0102; cfg_hw_ver = 4'h3; cfg_fw_ver = 4'h9; cfg_far_conn = 2'b10;
    cfg_receptacle = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    idle(3, 1'b1, "reset R1");
    // R3 each condition broken separately
    step(1'b1, 32'hFF000001, 1'b1, "unstructured R3"); idle(2, 1'b1, "R3");
    step(1'b1, 32'hFF018001, 1'b1, "other SID R3");    idle(2, 1'b1, "R3");
    step(1'b1, 32'hFF008002, 1'b1, "cmd 2 R3");        idle(2, 1'b1, "R3");
    step(1'b1, 32'hFF008041, 1'b1, "ACK type R3");     idle(2, 1'b1, "R3");
    step(1'b1, 32'hFF0080C1, 1'b1, "BUSY type R3");    idle(2, 1'b1, "R3");
    // R2/R4..R10 full reply, ready high
    step(1'b1, GOOD, 1'b1, "qualify R2"); idle(7, 1'b1, "drain R10");
    // R2 ignored bits set
    step(1'b1, 32'hFF00FF21, 1'b1, "reserved R2"); idle(7, 1'b1, "drain R10");
    // R10 ready toggling, active cable config
    cfg_host_cap = 1; cfg_dev_cap = 0; cfg_prod_type = 3'b100; cfg_modal = 1;
    cfg_vendor_id = 16'hFEDC; cfg_test_id = 20'h13579; cfg_product_id = 16'hA5A5;
    cfg_release = 16'h5A5A; cfg_hw_ver = 4'hC; cfg_fw_ver = 4'h1; cfg_far_conn = 2'b11;
    cfg_receptacle = 1'b1;
    step(1'b1, GOOD, 1'b0, "start R12");
    for (int i = 0; i < 14; i++) step(1'b0, 32'h0, logic'(i % 3 == 2), "stall R10");
    idle(4, 1'b1, "drain R10");
    // R11 abort mid-stream with qualifying request
    step(1'b1, GOOD, 1'b1, "start R12"); idle(2, 1'b1, "R9");
    step(1'b1, GOOD, 1'b1, "restart R11"); idle(7, 1'b1, "R11");
    // R11 abort with non-qualifying request
    step(1'b1, GOOD, 1'b1, "start R12"); idle(1, 1'b1, "R9");
    step(1'b1, 32'hFF008003, 1'b1, "abort-stop R11"); idle(3, 1'b1, "R11");
    // R11 request on the last word
    step(1'b1, GOOD, 1'b1, "start R12"); idle(4, 1'b1, "R9");
    step(1'b1, GOOD, 1'b0, "last-word R11"); idle(2, 1'b0, "R11 held");
    idle(6, 1'b1, "drain R10");
    // R1 reset mid-stream
    step(1'b1, GOOD, 1'b1, "start R12"); idle(1, 1'b1, "R9");
    @(negedge clk); rst = 1'b1; @(posedge clk); exp_q.delete(); exp_abort = 1'b0;
    @(negedge clk); rst = 1'b0;
    idle(3, 1'b1, "post-reset R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule